// File: doc/BRIEF.md
# Exception Control Register Unit

This block holds the control registers a simple processor consults when it takes an exception or an interrupt. Its status register keeps a three-level stack of mode and interrupt-enable pairs together with a per-level interrupt mask. Its cause register records the exception code and collects pending hardware interrupts. Two further registers keep the PC of the interrupted instruction and a faulting virtual address.

When the pipeline signals an exception, the unit pushes the mode stack, captures the PC and the code, and tells the fetch stage to redirect to a fixed handler vector. A return-from-exception command pops the stack in one cycle, so the enable bit and the mode bit always change together. Software reads the registers by number through one combinational read port. It writes them through one synchronous write port.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset, status, cause, exception PC and bad address all read 0. In the current pair, bit 1 is the mode bit (1 = user, 0 = kernel) and bit 0 is the interrupt enable (1 = enabled). Reset therefore selects kernel mode with all enables off.
- R2: On a cycle with `exc_valid` high, status bits 5:2 take the former bits 3:0 on the next cycle. Status bits 1:0 become 00, which is kernel mode with interrupts disabled.
- R3: On a cycle with `rfe` high and `exc_valid` low, status bits 3:0 take the former bits 5:2 on the next cycle. Bits 5:4 keep their value.
- R4: On an exception, the exception PC register takes `exc_pc` and cause bits 5:2 take `exc_code` on the next cycle.
- R5: `redirect` is high in the same cycle as `exc_valid`. `handler_pc` is always 0x80000080.
- R6: `rd_data` is combinational from `rd_addr`, with this register map:
  - 8: bad address
  - 12: status
  - 13: cause
  - 14: exception PC
  - any other number: reads 0
- R7: The bad-address register loads `bad_addr` only on a cycle where `exc_valid` and `bad_valid` are both high. On every other cycle it holds its value.
- R8: Cause bits 15:11 are the pending bits, one per interrupt level (bit 11 + i for `irq_in[i]`). A bit reads 1 the cycle after `irq_in[i]` is high. It clears the cycle after `irq_clr[i]` is high while `irq_in[i]` is low. If both are high, the set wins.
- R9: A write to number 12 updates status bits 15:11 (the interrupt mask, one bit per pending bit) and bits 5:0; the other status bits read 0. A write to number 14 replaces the exception PC. Writes to numbers 8, 13 or any other number change nothing. Every write shows on the next cycle.
- R10: An exception in the same cycle takes priority over a status or exception-PC write and over `rfe`. The mask bits keep their value across the exception.
- R11: `irq_req` is high exactly when status bit 0 is 1 and the pending bits ANDed with the mask bits are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_code | input | 4 | Exception type code |
| exc_pc | input | 32 | PC of the interrupted instruction |
| bad_valid | input | 1 | The exception carries a faulting address |
| bad_addr | input | 32 | Faulting virtual address |
| rfe | input | 1 | Return-from-exception command |
| irq_in | input | 5 | Hardware interrupt lines |
| irq_clr | input | 5 | Pending-bit service acknowledge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Register number to read |
| rd_data | output | 32 | Read data |
| redirect | output | 1 | Force fetch to the handler vector |
| handler_pc | output | 32 | Handler vector address |
| irq_req | output | 1 | Interrupt request to the pipeline |

## Verification
The assertions assume that every input is a known value on each clock edge after reset. They also assume that `exc_valid` and `rfe` may arrive together, because that case is resolved by priority and not excluded. The stimulus drives all inputs at the falling edge from a seeded generator. That generator mixes exceptions, returns, writes to mapped and unmapped numbers, and overlapping interrupt sets and clears. Directed steps add the collisions between exception, return and write, and the simultaneous set and clear of one pending bit.

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs #(
  parameter int          XLEN     = 32,
  parameter int          NIRQ     = 5,
  parameter int          CODE_W   = 4,
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] VEC_ADDR = 32'h8000_0080,
  parameter int          N_BAD    = 8,
  parameter int          N_STS    = 12,
  parameter int          N_CAUSE  = 13,
  parameter int          N_EPC    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              bad_valid,
  input  logic [XLEN-1:0]   bad_addr,
  input  logic              rfe,
  input  logic [NIRQ-1:0]   irq_in,
  input  logic [NIRQ-1:0]   irq_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [XLEN-1:0]   rd_data,
  output logic              redirect,
  output logic [XLEN-1:0]   handler_pc,
  output logic              irq_req
);
  localparam int PEND_LO = 11;
  localparam int PEND_HI = PEND_LO + NIRQ - 1;
  localparam int CODE_LO = 2;
  localparam int CODE_HI = CODE_LO + CODE_W - 1;

  logic [5:0]        stk_q;
  logic [NIRQ-1:0]   mask_q;
  logic [NIRQ-1:0]   pend_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_q;
  logic [XLEN-1:0]   bad_q;
  logic [XLEN-1:0]   sts_word;
  logic [XLEN-1:0]   cause_word;

  wire wr_sts = wr_en && (wr_addr == ADDR_W'(N_STS));
  wire wr_epc = wr_en && (wr_addr == ADDR_W'(N_EPC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk_q  <= '0;
      mask_q <= '0;
    end else if (exc_valid) begin
      stk_q  <= {stk_q[3:0], 2'b00};
    end else if (rfe) begin
      stk_q  <= {stk_q[5:4], stk_q[5:2]};
    end else if (wr_sts) begin
      stk_q  <= wr_data[5:0];
      mask_q <= wr_data[PEND_HI:PEND_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q  <= '0;
      code_q <= '0;
    end else if (exc_valid) begin
      epc_q  <= exc_pc;
      code_q <= exc_code;
    end else if (wr_epc) begin
      epc_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      bad_q <= '0;
    else if (exc_valid && bad_valid) bad_q <= bad_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~irq_clr) | irq_in;
  end

  always_comb begin
    sts_word = '0;
    sts_word[5:0] = stk_q;
    sts_word[PEND_HI:PEND_LO] = mask_q;
    cause_word = '0;
    cause_word[CODE_HI:CODE_LO] = code_q;
    cause_word[PEND_HI:PEND_LO] = pend_q;
  end

  always_comb begin
    case (rd_addr)
      ADDR_W'(N_BAD):   rd_data = bad_q;
      ADDR_W'(N_STS):   rd_data = sts_word;
      ADDR_W'(N_CAUSE): rd_data = cause_word;
      ADDR_W'(N_EPC):   rd_data = epc_q;
      default:          rd_data = '0;
    endcase
  end

  assign redirect   = exc_valid;
  assign handler_pc = VEC_ADDR;
  assign irq_req    = stk_q[0] && |(pend_q & mask_q);
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk #(
  parameter int XLEN = 32,
  parameter int NIRQ = 5,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic [XLEN-1:0]   exc_pc,
  input logic              bad_valid,
  input logic [XLEN-1:0]   bad_addr,
  input logic              rfe,
  input logic [NIRQ-1:0]   irq_in,
  input logic [NIRQ-1:0]   irq_clr,
  input logic [5:0]        stk,
  input logic [NIRQ-1:0]   mask,
  input logic [NIRQ-1:0]   pend,
  input logic [CODE_W-1:0] code,
  input logic [XLEN-1:0]   epc,
  input logic [XLEN-1:0]   bad,
  input logic              irq_req
);
  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (stk[5:2] == $past(stk[3:0])) && (stk[1:0] == 2'b00));
  p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_valid) |=> (stk[3:0] == $past(stk[5:2])) && (stk[5:4] == $past(stk[5:4])));
  p_epc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (epc == $past(exc_pc)) && (code == $past(exc_code)));
  p_bad_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && bad_valid) |=> bad == $past(bad_addr));
  p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid && bad_valid) |=> $stable(bad));
  p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_in) |=> ((pend & $past(irq_in)) == $past(irq_in)));
  p_pend_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_clr & ~irq_in)) |=> ((pend & $past(irq_clr & ~irq_in)) == '0));
  p_mask_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> $stable(mask));
  p_req_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stk[0] |-> !irq_req);
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk #(.XLEN(XLEN), .NIRQ(NIRQ), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
  .exc_pc(exc_pc), .bad_valid(bad_valid), .bad_addr(bad_addr), .rfe(rfe),
  .irq_in(irq_in), .irq_clr(irq_clr), .stk(stk_q), .mask(mask_q),
  .pend(pend_q), .code(code_q), .epc(epc_q), .bad(bad_q), .irq_req(irq_req)
);

// File: tb/sim_exc_ctrl_regs.sv
`timescale 1ns/1ps
module sim_exc_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        bad_valid = 1'b0;
  logic [31:0] bad_addr = '0;
  logic        rfe = 1'b0;
  logic [4:0]  irq_in = '0;
  logic [4:0]  irq_clr = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        redirect;
  logic [31:0] handler_pc;
  logic        irq_req;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [5:0]  m_stk;
  logic [4:0]  m_mask, m_pend;
  logic [3:0]  m_code;
  logic [31:0] m_epc, m_bad;

  always #4 clk = ~clk;

  exc_ctrl_regs u0 (.*);

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'd8:  return m_bad;
      5'd12: return {16'h0, m_mask, 5'h0, m_stk};
      5'd13: return {16'h0, m_pend, 5'h0, m_code, 2'b00};
      5'd14: return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      m_stk = '0; m_mask = '0; m_pend = '0; m_code = '0; m_epc = '0; m_bad = '0;
    end else begin
      if (exc_valid) begin
        m_stk = {m_stk[3:0], 2'b00}; m_epc = exc_pc; m_code = exc_code;
        if (bad_valid) m_bad = bad_addr;
      end else begin
        if (rfe) m_stk = {m_stk[5:4], m_stk[5:2]};
        else if (wr_en && wr_addr == 5'd12) begin
          m_stk = wr_data[5:0]; m_mask = wr_data[15:11];
        end
        if (wr_en && wr_addr == 5'd14) m_epc = wr_data;
      end
      m_pend = (m_pend & ~irq_clr) | irq_in;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    exc_valid = 0; bad_valid = 0; rfe = 0; irq_in = '0; irq_clr = '0; wr_en = 0;
  endtask

  task automatic check_all(input string tag);
    logic [4:0] addrs [5] = '{5'd8, 5'd12, 5'd13, 5'd14, 5'd3};
    foreach (addrs[k]) begin
      rd_addr = addrs[k];
      #1;
      chk({tag, " R6 read"}, rd_data, exp_rd(addrs[k]));
    end
    chk({tag, " R11 irq_req"}, {31'h0, irq_req},
        {31'h0, m_stk[0] & (|(m_pend & m_mask))});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    check_all("R1 reset");

    wr(5'd13, 32'hFFFF_FFFF); tick(); idle();
    check_all("R9 cause write ignored");
    wr(5'd8, 32'h1234_5678); tick(); idle();
    check_all("R9 badaddr write ignored");
    wr(5'd12, 32'hFFFF_FFFF); tick(); idle();
    chk("R9 status write mask", exp_rd(5'd12), 32'h0000_F83F);
    check_all("R9 status write");
    wr(5'd12, 32'h0000_F80D); tick(); idle();
    wr(5'd14, 32'hCAFE_0004); tick(); idle();
    check_all("R9 epc write");

    exc_valid = 1; exc_code = 4'hA; exc_pc = 32'h0040_0010; bad_valid = 1; bad_addr = 32'hDEAD_BEEC;
    #1;
    chk("R5 redirect", {31'h0, redirect}, 32'h1);
    chk("R5 vector", handler_pc, 32'h8000_0080);
    tick(); idle();
    chk("R2 push", exp_rd(5'd12), 32'h0000_F834);
    check_all("R2 R4 R7 entry");

    exc_valid = 1; exc_code = 4'h3; exc_pc = 32'h0000_0100; bad_valid = 0; bad_addr = 32'h1111_1111;
    tick(); idle();
    check_all("R7 bad hold");

    rfe = 1; tick(); idle();
    check_all("R3 pop");
    rfe = 1; tick(); idle();
    check_all("R3 pop twice");

    exc_valid = 1; rfe = 1; exc_code = 4'h5; exc_pc = 32'h0000_0200;
    wr(5'd12, 32'h0000_0003); tick(); idle();
    check_all("R10 exc beats rfe and write");
    exc_valid = 1; wr(5'd14, 32'h5555_AAAA); exc_pc = 32'h0000_0300; tick(); idle();
    check_all("R10 exc beats epc write");

    wr(5'd12, 32'h0000_F801); tick(); idle();
    irq_in = 5'b00101; tick(); idle();
    check_all("R8 R11 pending set");
    irq_in = 5'b00001; irq_clr = 5'b00101; tick(); idle();
    check_all("R8 set wins over clear");
    irq_clr = 5'b11111; tick(); idle();
    check_all("R8 clear");

    for (int n = 0; n < 2000; n++) begin
      exc_valid = ($urandom_range(7) == 0);
      exc_code  = 4'($urandom);
      exc_pc    = $urandom;
      bad_valid = 1'($urandom);
      bad_addr  = $urandom;
      rfe       = ($urandom_range(7) == 0);
      irq_in    = 5'($urandom & $urandom);
      irq_clr   = 5'($urandom);
      wr_en     = ($urandom_range(3) == 0);
      case ($urandom_range(4))
        0: wr_addr = 5'd8;
        1: wr_addr = 5'd12;
        2: wr_addr = 5'd13;
        3: wr_addr = 5'd14;
        default: wr_addr = 5'($urandom);
      endcase
      wr_data = $urandom;
      #1;
      chk("R5 random redirect", {31'h0, redirect}, {31'h0, exc_valid});
      tick();
      rd_addr = 5'($urandom);
      #1;
      chk("R6 random read", rd_data, exp_rd(rd_addr));
      rd_addr = 5'd12;
      #1;
      chk("R2 R3 random status", rd_data, exp_rd(5'd12));
      chk("R11 random irq_req", {31'h0, irq_req},
          {31'h0, m_stk[0] & (|(m_pend & m_mask))});
    end
    idle();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule